// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block produces the external bus timing for an 8-bit core with a 16-bit address space. The low address byte and the data byte share one multiplexed bus. The core places a request with an address, a cycle type and write data, and holds it until `done_o` pulses. The sequencer then runs one machine cycle on the pins and returns any read data on `rdata_o`.

Every bus T-state lasts two clocks of `clk_i`. An internal phase bit marks the second clock as the T-state boundary, so half-T-state events stay on a single clock edge. A machine cycle starts with T1. In T1 the address goes out and the latch strobe is pulsed. T2 follows, then zero or more wait states while `ready_i` is low, then T3.

Tri-state is modelled as one output enable per pin group: upper address, multiplexed bus, and the control group (read strobe, write strobe and memory/IO select). The bus input and output are separate. Another master can take all three groups through `hold_i`/`hlda_o`, but only between machine cycles. A halt cycle leaves the groups floating until the next request.

Top module: `mux_bus_seq`

## Requirements
- R1: Requests (`req_i` high) are taken only at a T-state boundary while idle or halted. A non-halt cycle then runs T1, T2, any wait states and T3, each two clocks long. `done_o` is high for exactly the one clock after the cycle's last clock, and the sequencer spends one idle T-state before it takes the next request.
- R2: During T1, `ad_o` carries address bits 7:0 with `ad_oe_o` high, and `addr_hi_o` carries address bits 15:8. `ale_o` is high for the first clock of T1 only, with both strobes inactive.
- R3: `type_i` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 IO read, 4 IO write, and 5 to 7 halt. `status_o` is 11 for fetch, 10 for either read, 01 for either write and 00 for halt. `io_m_o` is 1 only for the IO types. Both outputs hold the code of the latest accepted request.
- R4: `ready_i` is sampled at the last clock of T2 and of each wait state. A low sample adds one more wait T-state, and the active strobe stays low throughout. With N wait states, `rd_n_o` is low for 4+2N clocks and `wr_n_o` is low for 3+2N clocks.
- R5: In a write cycle, `ad_o` holds the write data with `ad_oe_o` high from T2 to the end of T3. `wr_n_o` is low from the start of T2 through the first clock of T3, and it rises while the data is unchanged.
- R6: In a read or fetch cycle, `rd_n_o` is low from T2 to the end of T3 and `ad_oe_o` is low. `rdata_o` takes `ad_i` at the final clock edge of T3 and keeps it until the next read.
- R7: `hold_i` is honoured only at a boundary while idle or halted, or at the end of T3, and it wins over a pending request. While the hold is granted, `hlda_o` is high and all three enables are low.
- R8: When `hold_i` is low at a boundary during the hold, `hlda_o` falls at that edge. The address and control enables come back one clock (half a T-state) later.
- R9: A halt request runs T1 with status 00, pulses `done_o`, and then drives all three enables low. A later request goes straight into T1.
- R10: After reset and in the idle state, `addr_hi_oe_o` and `ctl_oe_o` are high, `ad_oe_o`, `ale_o`, `done_o` and `hlda_o` are low, both strobes are high, and `status_o` is 00. After reset `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, two per bus T-state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request, held until done |
| type_i | input | 3 | Cycle type code |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Captured read data |
| addr_hi_o | output | 8 | Upper address byte |
| addr_hi_oe_o | output | 1 | Upper address enable |
| ad_o | output | 8 | Multiplexed bus, driven value |
| ad_i | input | 8 | Multiplexed bus, received value |
| ad_oe_o | output | 1 | Multiplexed bus enable |
| ale_o | output | 1 | Address latch strobe |
| status_o | output | 2 | Cycle status code |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 for IO, 0 for memory |
| ctl_oe_o | output | 1 | Enable for strobes and io_m_o |
| ready_i | input | 1 | Device ready, low inserts waits |
| hold_i | input | 1 | Bus request from another master |
| hlda_o | output | 1 | Bus grant to the other master |

## Verification
The assertions assume that `req_i` and `type_i` stay stable from the moment they are raised until `done_o`, and that `hold_i` and `ready_i` change only between clock edges. The bench applies all of its inputs on the falling edge and holds each request until it sees the completion pulse. It raises and drops hold requests at arbitrary clocks, both inside machine cycles and while the sequencer is idle or halted. The device model drives `ready_i` from a wait counter that it loads when it sees the latch strobe.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HALT, ST_HOLD
  } bus_st_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       io;
    logic       halt;
    logic [1:0] code;
  } cyc_dec_t;

  function automatic cyc_dec_t cyc_decode(logic [2:0] t);
    cyc_dec_t d;
    d = '{rd: 1'b0, wr: 1'b0, io: 1'b0, halt: 1'b0, code: 2'b00};
    case (t)
      3'd0: begin d.rd = 1'b1; d.code = 2'b11; end
      3'd1: begin d.rd = 1'b1; d.code = 2'b10; end
      3'd2: begin d.wr = 1'b1; d.code = 2'b01; end
      3'd3: begin d.rd = 1'b1; d.io = 1'b1; d.code = 2'b10; end
      3'd4: begin d.wr = 1'b1; d.io = 1'b1; d.code = 2'b01; end
      default: d.halt = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mux_bus_phase.sv
module mux_bus_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o,
  output logic bnd_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;
  // second clock of each T-state closes it
  assign bnd_o   = phase_q;
endmodule

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
  import mux_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bnd_i,
  input  logic              req_i,
  input  logic [TW-1:0]     type_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              ready_i,
  input  logic              hold_i,
  input  logic [DW-1:0]     ad_i,
  output bus_st_e           st_o,
  output cyc_dec_t          dec_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              rel_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o
);
  localparam logic [TW-1:0] HALT_CODE = TW'(5);

  bus_st_e        st_q, st_d;
  cyc_dec_t       dec_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic           rel_q, rel_d, done_q, take, fin;

  always_comb begin
    st_d  = st_q;
    take  = 1'b0;
    fin   = 1'b0;
    rel_d = 1'b0;
    if (bnd_i) begin
      case (st_q)
        ST_IDLE, ST_HALT: begin
          if (hold_i) st_d = ST_HOLD;
          else if (req_i) begin
            st_d = ST_T1;
            take = 1'b1;
          end
        end
        ST_T1: begin
          if (dec_q.halt) begin
            st_d = ST_HALT;
            fin  = 1'b1;
          end else begin
            st_d = ST_T2;
          end
        end
        ST_T2, ST_TW: st_d = ready_i ? ST_T3 : ST_TW;
        ST_T3: begin
          fin  = 1'b1;
          st_d = hold_i ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: begin
          if (!hold_i) begin
            st_d  = ST_IDLE;
            rel_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dec_q   <= cyc_decode(HALT_CODE);
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rel_q  <= rel_d;
      done_q <= fin;
      if (take) begin
        dec_q   <= cyc_decode(type_i);
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (bnd_i && st_q == ST_T3 && dec_q.rd) rdata_q <= ad_i;
    end
  end

  assign st_o    = st_q;
  assign dec_o   = dec_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rel_o   = rel_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mux_bus_drive.sv
module mux_bus_drive
  import mux_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  bus_st_e         st_i,
  input  logic            phase_i,
  input  logic            rel_i,
  input  cyc_dec_t        dec_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic            addr_hi_oe_o,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic            ale_o,
  output logic [1:0]      status_o,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output logic            io_m_o,
  output logic            ctl_oe_o,
  output logic            hlda_o
);
  logic data_ph, drive;

  always_comb begin
    data_ph      = (st_i == ST_T2) || (st_i == ST_TW) || (st_i == ST_T3);
    drive        = ((st_i == ST_IDLE) || (st_i == ST_T1) || data_ph) && !rel_i;
    addr_hi_oe_o = drive;
    ctl_oe_o     = drive;
    ad_oe_o      = (st_i == ST_T1) || (data_ph && dec_i.wr);
    ale_o        = (st_i == ST_T1) && !phase_i;
    rd_n_o       = !(data_ph && dec_i.rd);
    // write strobe ends one clock before data is released
    wr_n_o       = !(dec_i.wr && (data_ph && !(st_i == ST_T3 && phase_i)));
    ad_o         = (st_i == ST_T1) ? addr_i[DW-1:0] : wdata_i;
    addr_hi_o    = addr_i[AW-1:DW];
    status_o     = dec_i.code;
    io_m_o       = dec_i.io;
    hlda_o       = (st_i == ST_HOLD);
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [TW-1:0]    type_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic             addr_hi_oe_o,
  output logic [DW-1:0]    ad_o,
  input  logic [DW-1:0]    ad_i,
  output logic             ad_oe_o,
  output logic             ale_o,
  output logic [1:0]       status_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             io_m_o,
  output logic             ctl_oe_o,
  input  logic             ready_i,
  input  logic             hold_i,
  output logic             hlda_o
);
  logic          phase, bnd, rel;
  bus_st_e       st;
  cyc_dec_t      dec;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  mux_bus_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .bnd_o   (bnd)
  );

  mux_bus_fsm #(.AW(AW), .DW(DW), .TW(TW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bnd_i   (bnd),
    .req_i   (req_i),
    .type_i  (type_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ready_i (ready_i),
    .hold_i  (hold_i),
    .ad_i    (ad_i),
    .st_o    (st),
    .dec_o   (dec),
    .addr_o  (addr_q),
    .wdata_o (wdata_q),
    .rel_o   (rel),
    .done_o  (done_o),
    .rdata_o (rdata_o)
  );

  mux_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .st_i         (st),
    .phase_i      (phase),
    .rel_i        (rel),
    .dec_i        (dec),
    .addr_i       (addr_q),
    .wdata_i      (wdata_q),
    .addr_hi_o    (addr_hi_o),
    .addr_hi_oe_o (addr_hi_oe_o),
    .ad_o         (ad_o),
    .ad_oe_o      (ad_oe_o),
    .ale_o        (ale_o),
    .status_o     (status_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .io_m_o       (io_m_o),
    .ctl_oe_o     (ctl_oe_o),
    .hlda_o       (hlda_o)
  );
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          addr_hi_oe_o,
  input logic [DW-1:0] ad_o,
  input logic          ad_oe_o,
  input logic          ale_o,
  input logic          rd_n_o,
  input logic          wr_n_o,
  input logic          ctl_oe_o,
  input logic          hlda_o
);
  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_ale_addr_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && addr_hi_oe_o && rd_n_o && wr_n_o));

  assert_ale_one_clock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  assert_single_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_oe_o |-> (rd_n_o || wr_n_o));

  assert_wr_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && $rose(wr_n_o)) |-> (ad_oe_o && $stable(ad_o)));

  assert_hold_float_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !(addr_hi_oe_o || ad_oe_o || ctl_oe_o));

  assert_reclaim_late_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_o) |-> !(addr_hi_oe_o || ctl_oe_o));
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_o       (done_o),
  .addr_hi_oe_o (addr_hi_oe_o),
  .ad_o         (ad_o),
  .ad_oe_o      (ad_oe_o),
  .ale_o        (ale_o),
  .rd_n_o       (rd_n_o),
  .wr_n_o       (wr_n_o),
  .ctl_oe_o     (ctl_oe_o),
  .hlda_o       (hlda_o)
);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;
  localparam int M_IDLE = 0, M_T1 = 1, M_T2 = 2, M_TW = 3, M_T3 = 4, M_HALT = 5, M_HOLD = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  typ = 3'd0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready = 1'b1;
  logic        hold = 1'b0;
  logic [7:0]  ad_in;
  logic        done, addr_hi_oe, ad_oe, ale, rd_n, wr_n, io_m, ctl_oe, hlda;
  logic [7:0]  rdata, addr_hi, ad_out;
  logic [1:0]  status;

  int vectors = 0;
  int misses  = 0;
  int cfg_waits = 0;

  always #2 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .type_i(typ), .addr_i(addr),
    .wdata_i(wdata), .done_o(done), .rdata_o(rdata), .addr_hi_o(addr_hi),
    .addr_hi_oe_o(addr_hi_oe), .ad_o(ad_out), .ad_i(ad_in), .ad_oe_o(ad_oe),
    .ale_o(ale), .status_o(status), .rd_n_o(rd_n), .wr_n_o(wr_n), .io_m_o(io_m),
    .ctl_oe_o(ctl_oe), .ready_i(ready), .hold_i(hold), .hlda_o(hlda)
  );

  task automatic chk(string tag, string nm, logic [15:0] act, logic [15:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // device side: memory and IO space keyed by {io, low address}
  logic [7:0] dev_mem [512];
  logic [7:0] ref_mem [512];
  logic [8:0] dev_key = '0;
  int         dev_wait = 0;
  assign ad_in = dev_mem[dev_key];

  // reference model
  int          m_st, m_ph, m_wseen;
  logic        m_done, m_rel;
  logic [2:0]  m_typ;
  logic [15:0] m_addr;
  logic [7:0]  m_wdata, m_rdata;

  function automatic logic is_rd(logic [2:0] t);
    return t == 3'd0 || t == 3'd1 || t == 3'd3;
  endfunction
  function automatic logic is_wr(logic [2:0] t);
    return t == 3'd2 || t == 3'd4;
  endfunction
  function automatic logic [1:0] code_of(logic [2:0] t);
    if (t == 3'd0) return 2'b11;
    if (is_rd(t)) return 2'b10;
    if (is_wr(t)) return 2'b01;
    return 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_ph = 0; m_wseen = 0; m_done = 0; m_rel = 0;
      m_typ = 3'd5; m_addr = '0; m_wdata = '0; m_rdata = '0;
    end else begin
      m_done = 0;
      m_rel  = 0;
      if (m_ph == 1) begin
        case (m_st)
          M_IDLE, M_HALT:
            if (hold) m_st = M_HOLD;
            else if (req) begin
              m_st = M_T1; m_typ = typ; m_addr = addr; m_wdata = wdata; m_wseen = 0;
            end
          M_T1:
            if (!is_rd(m_typ) && !is_wr(m_typ)) begin m_st = M_HALT; m_done = 1; end
            else m_st = M_T2;
          M_T2, M_TW:
            if (m_wseen < cfg_waits) begin m_wseen++; m_st = M_TW; end
            else m_st = M_T3;
          M_T3: begin
            if (is_wr(m_typ)) ref_mem[{m_typ == 3'd4, m_addr[7:0]}] = m_wdata;
            else m_rdata = ref_mem[{m_typ == 3'd3, m_addr[7:0]}];
            m_done = 1;
            m_st = hold ? M_HOLD : M_IDLE;
          end
          M_HOLD: if (!hold) begin m_st = M_IDLE; m_rel = 1; end
          default: m_st = M_IDLE;
        endcase
      end
      m_ph = 1 - m_ph;
    end
  end

  // per-clock comparison and device behaviour, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic busy, dat, drv, e_ad_oe, e_rd_n, e_wr_n;
      busy = (m_st == M_T1) || (m_st == M_T2) || (m_st == M_TW) || (m_st == M_T3);
      dat  = busy && (m_st != M_T1);
      drv  = (m_st == M_IDLE || busy) && !m_rel;
      e_ad_oe = (m_st == M_T1) || (dat && is_wr(m_typ));
      e_rd_n  = !(dat && is_rd(m_typ));
      e_wr_n  = !(dat && is_wr(m_typ) && !(m_st == M_T3 && m_ph == 1));
      vectors++;
      chk("R1", "done_o", 16'(done), 16'(m_done));
      chk("R2", "ale_o", 16'(ale), 16'(m_st == M_T1 && m_ph == 0));
      chk("R3", "status_o", 16'(status), 16'(code_of(m_typ)));
      chk("R6", "ad_oe_o", 16'(ad_oe), 16'(e_ad_oe));
      chk("R6", "rdata_o", 16'(rdata), 16'(m_rdata));
      chk("R7", "hlda_o", 16'(hlda), 16'(m_st == M_HOLD));
      chk("R8", "addr_hi_oe_o", 16'(addr_hi_oe), 16'(drv));
      chk("R8", "ctl_oe_o", 16'(ctl_oe), 16'(drv));
      if (drv) begin
        chk("R2", "addr_hi_o", 16'(addr_hi), 16'(m_addr[15:8]));
        chk("R6", "rd_n_o", 16'(rd_n), 16'(e_rd_n));
        chk("R5", "wr_n_o", 16'(wr_n), 16'(e_wr_n));
        chk("R3", "io_m_o", 16'(io_m), 16'(m_typ == 3'd3 || m_typ == 3'd4));
      end
      if (e_ad_oe)
        chk("R5", "ad_o", 16'(ad_out), (m_st == M_T1) ? 16'(m_addr[7:0]) : 16'(m_wdata));
      // device model
      if (ale) begin
        dev_key  = {io_m, ad_out};
        dev_wait = cfg_waits;
      end
      if (ctl_oe && !wr_n && ad_oe) dev_mem[dev_key] = ad_out;
      ready = (dev_wait == 0);
      if (m_ph == 1 && ctl_oe && (!rd_n || !wr_n) && dev_wait > 0) dev_wait--;
    end
  end

  task automatic do_req(input logic [2:0] t, input logic [15:0] a, input logic [7:0] d,
                        output int rd_low, output int wr_low);
    rd_low = 0;
    wr_low = 0;
    @(negedge clk);
    req = 1'b1; typ = t; addr = a; wdata = d;
    do begin
      @(negedge clk);
      #0.1;
      if (ctl_oe && !rd_n) rd_low++;
      if (ctl_oe && !wr_n) wr_low++;
    end while (!done);
    req = 1'b0;
  endtask

  task automatic run(input logic [2:0] t, input logic [15:0] a, input logic [7:0] d, input int w);
    int rl, wl;
    cfg_waits = w;
    do_req(t, a, d, rl, wl);
    if (is_rd(t)) begin
      vectors++;
      chk("R4", "read strobe clocks", 16'(rl), 16'(4 + 2 * w));
    end
    if (is_wr(t)) begin
      vectors++;
      chk("R4", "write strobe clocks", 16'(wl), 16'(3 + 2 * w));
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      dev_mem[i] = 8'(i * 37 + 11);
      ref_mem[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    // R10 reset values
    vectors++;
    chk("R10", "reset ale/done/hlda", {13'b0, ale, done, hlda}, 16'h0000);
    chk("R10", "reset strobes", {14'b0, rd_n, wr_n}, 16'h0003);
    chk("R10", "reset enables", {13'b0, addr_hi_oe, ctl_oe, ad_oe}, 16'h0006);
    chk("R10", "reset status/rdata", {6'b0, status, rdata}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run(3'd0, 16'h1234, 8'h00, 0);   // fetch
    run(3'd1, 16'h5678, 8'h00, 1);   // memory read, one wait
    run(3'd2, 16'h9abc, 8'h5a, 0);   // memory write
    run(3'd1, 16'h9abc, 8'h00, 2);   // read back
    run(3'd4, 16'h0042, 8'hc3, 2);   // IO write
    run(3'd3, 16'h0042, 8'h00, 0);   // IO read
    run(3'd0, 16'hfe01, 8'h00, 3);

    // hold while idle
    hold = 1'b1;
    repeat (9) @(negedge clk);
    hold = 1'b0;
    repeat (5) @(negedge clk);

    // hold raised mid-cycle: granted only after T3 (R7)
    fork
      run(3'd2, 16'h3311, 8'h77, 1);
      begin
        repeat (4) @(negedge clk);
        hold = 1'b1;
        repeat (14) @(negedge clk);
        hold = 1'b0;
      end
    join
    repeat (4) @(negedge clk);

    // hold and request together: hold wins (R7)
    fork
      run(3'd1, 16'h3311, 8'h00, 0);
      begin
        @(negedge clk);
        hold = 1'b1;
        repeat (7) @(negedge clk);
        hold = 1'b0;
      end
    join

    // halt, then floating groups (R9)
    run(3'd5, 16'h0100, 8'h00, 0);
    vectors++;
    chk("R9", "halted enables", {13'b0, addr_hi_oe, ctl_oe, ad_oe}, 16'h0000);
    run(3'd0, 16'h0100, 8'h00, 0);
    // idle drive (R10)
    vectors++;
    chk("R10", "idle enables", {13'b0, addr_hi_oe, ctl_oe, ad_oe}, 16'h0006);
    run(3'd7, 16'h0200, 8'h00, 0);   // code 7 also halts
    vectors++;
    chk("R9", "halted enables code 7", {13'b0, addr_hi_oe, ctl_oe, ad_oe}, 16'h0000);
    hold = 1'b1;                      // hold from halted
    repeat (8) @(negedge clk);
    hold = 1'b0;
    repeat (4) @(negedge clk);
    run(3'd3, 16'h0042, 8'h00, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule